// File: doc/BRIEF.md
# I2C Controller Interrupt Vector and Status Unit

This unit collects the event indications of an I2C master/slave controller and turns them into something a processor can service. Seven one-cycle event pulses (arbitration lost, no-acknowledge, register access ready, receive data ready, transmit data ready, stop condition seen, addressed as slave) each set a sticky flag. A mask register selects which flags may interrupt, a single level interrupt line goes high while any enabled flag is pending, and a vector register reports the highest-priority enabled flag as a small code so that the service routine knows at once which event to handle.

Software clears flags by writing ones to the status register, by reading the vector (for most events), or, for the two data-ready events, by touching the data registers of the controller, which this unit sees as two strobes. Two level indications from the rest of the controller, bus busy and receive shift register full, are shown read-only in the status word. The register access port is a plain address/read/write strobe interface with combinational read data.

Top module: `i2c_irq_vector`

## Requirements
- R1: An event pulse on `evt_pulse[i]` sets flag i at the next clock edge; flag i is shown at bit i of the status word (address 1). Event index order: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as slave.
- R2: A write to the status word clears every flag whose bit in the written data is 1 and leaves flags whose bit is 0 unchanged.
- R3: When an event pulse and a clearing action for the same flag occur in the same cycle, the flag is set after the edge.
- R4: The mask register (address 0) holds one enable bit per event at the event's index, resets to 0, reads back with bits 7 and up as 0, and `irq` is high exactly while some flag is set whose mask bit is 1.
- R5: The vector register (address 2) reads index+1 of the lowest-index flag that is both set and enabled (1 arbitration lost ... 7 addressed as slave), and reads 0 when no enabled flag is pending; masked flags never appear in it.
- R6: A read of the vector (`reg_rd` with address 2) clears the flag it reported at the next edge, except when the code is 4 (receive ready) or 5 (transmit ready), which stay set.
- R7: The receive ready flag clears on a `rxd_read` strobe and the transmit ready flag clears on a `txd_write` strobe.
- R8: Status bit 11 shows `rsr_full` and bit 12 shows `bus_busy` in the same cycle; writes to those positions change nothing.
- R9: After reset all flags and the mask are 0, `irq` is low and the vector reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 7 | One-cycle event pulses, one per event index |
| rxd_read | input | 1 | Strobe: receive data register was read |
| txd_write | input | 1 | Strobe: transmit data register was written |
| rsr_full | input | 1 | Receive shift register full level |
| bus_busy | input | 1 | Bus busy level |
| reg_addr | input | 2 | Register address: 0 mask, 1 status, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data for `reg_addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
Flags, the mask and every clearing action take effect one clock edge after their strobe, while the read data, the vector and `irq` follow the stored state combinationally, so the status bits for bus busy and shift register full are due in the same cycle as the input. The bench drives inputs two nanoseconds after a rising edge and samples the read data in that same quiet window, one edge after the strobe it is checking. Collisions of set and clear, vector reads that must not clear the data-ready events, and writes into the read-only bits are checked as directed cases after a table of mask/event vectors.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt vector/status unit.
// Assumes seven events whose index fixes both mask bit and status bit.
package i2c_irq_pkg;
    localparam int NUM_EV  = 7;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int VEC_W   = $clog2(NUM_EV + 1);
    localparam int RX_IDX  = 3;
    localparam int TX_IDX  = 4;
    localparam int RSF_BIT = 11;
    localparam int BB_BIT  = 12;

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2);

    typedef enum logic [VEC_W-1:0] {
        V_NONE  = 3'd0,
        V_ARB   = 3'd1,
        V_NACK  = 3'd2,
        V_ACC   = 3'd3,
        V_RX    = 3'd4,
        V_TX    = 3'd5,
        V_STOP  = 3'd6,
        V_SLAVE = 3'd7
    } vec_code_e;
endpackage

// File: rtl/i2c_irq_flag_bank.sv
// Sticky event flags. Each flag is set by its event pulse and cleared by
// a write-one-to-clear, a vector-read clear, or (for the two data-ready
// flags) a data register strobe. A set in the same cycle as a clear wins.
// Assumes all clear inputs are single-cycle strobes.
module i2c_irq_flag_bank #(
    parameter int N      = 7,
    parameter int RX_POS = 3,
    parameter int TX_POS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] vclr_i,
    input  logic         rxd_read,
    input  logic         txd_write,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic strobe_clr;
        logic flag_q;

        // Select the data-register strobe that clears this flag, if any.
        if (i == RX_POS) begin : g_rx
            assign strobe_clr = rxd_read;
        end else if (i == TX_POS) begin : g_tx
            assign strobe_clr = txd_write;
        end else begin : g_none
            assign strobe_clr = 1'b0;
        end

        // Hold the flag; a new event overrides any clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else
                flag_q <= set_i[i] | (flag_q & ~(w1c_i[i] | vclr_i[i] | strobe_clr));
        end

        assign flags_o[i] = flag_q;
    end
endmodule

// File: rtl/i2c_irq_prio.sv
// Fixed-priority encoder: lowest set request index wins. Outputs the
// index plus one as a code (0 when nothing requests) and a one-hot grant.
module i2c_irq_prio #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] code_o,
    output logic [N-1:0] grant_o
);
    // Scan from the highest index down so the lowest one is left standing.
    always_comb begin
        code_o  = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o     = W'(i + 1);
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_regs.sv
// Register decode for the interrupt unit: mask register storage, status
// write-one-to-clear decode, vector-read clear and the read data mux.
// Assumes read data is consumed combinationally in the strobe cycle.
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  flags_i,
    input  logic [VW-1:0] code_i,
    input  logic [N-1:0]  grant_i,
    input  logic          rsr_full,
    input  logic          bus_busy,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  w1c_o,
    output logic [N-1:0]  vclr_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [N-1:0] KEEP_ON_READ = N'((1 << RX_IDX) | (1 << TX_IDX));

    logic [N-1:0] mask_q;
    logic         unused_wdata_hi;

    assign unused_wdata_hi = |wdata_i[DW-1:N];

    // Mask register: software-written enable per event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_i && addr_i == A_MASK)
            mask_q <= wdata_i[N-1:0];
    end

    assign mask_o = mask_q;

    // Clear requests towards the flag bank.
    always_comb begin
        w1c_o  = (wr_i && addr_i == A_STAT) ? wdata_i[N-1:0] : '0;
        vclr_o = (rd_i && addr_i == A_VEC) ? (grant_i & ~KEEP_ON_READ) : '0;
    end

    // Read data mux; status shows flags plus the two read-only levels.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_MASK: rdata_o[N-1:0] = mask_q;
            A_STAT: begin
                rdata_o[N-1:0]  = flags_i;
                rdata_o[RSF_BIT] = rsr_full;
                rdata_o[BB_BIT]  = bus_busy;
            end
            A_VEC:  rdata_o[VW-1:0] = code_i;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_vector.sv
// Top of the I2C interrupt vector/status unit. Event pulses set sticky
// flags, the mask gates them into one level interrupt and a priority
// vector. Assumes event pulses and register strobes are synchronous to clk.
module i2c_irq_vector
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_pulse,
    input  logic          rxd_read,
    input  logic          txd_write,
    input  logic          rsr_full,
    input  logic          bus_busy,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic [N-1:0]  flags;
    logic [N-1:0]  mask;
    logic [N-1:0]  pending;
    logic [N-1:0]  w1c;
    logic [N-1:0]  vclr;
    logic [N-1:0]  grant;
    logic [VW-1:0] vec_code;

    i2c_irq_flag_bank #(.N(N), .RX_POS(RX_IDX), .TX_POS(TX_IDX)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .w1c_i(w1c),
        .vclr_i(vclr), .rxd_read(rxd_read), .txd_write(txd_write),
        .flags_o(flags)
    );

    // Only enabled flags compete for the vector and the interrupt.
    assign pending = flags & mask;

    i2c_irq_prio #(.N(N), .W(VW)) u_prio (
        .req_i(pending), .code_o(vec_code), .grant_o(grant)
    );

    i2c_irq_regs #(.N(N), .DW(DW), .AW(AW), .VW(VW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr),
        .rd_i(reg_rd), .wdata_i(reg_wdata), .flags_i(flags),
        .code_i(vec_code), .grant_i(grant), .rsr_full(rsr_full),
        .bus_busy(bus_busy), .mask_o(mask), .w1c_o(w1c), .vclr_o(vclr),
        .rdata_o(reg_rdata)
    );

    // Level interrupt while any enabled flag is pending.
    assign irq = |pending;
endmodule

// File: rtl/i2c_irq_vector_chk.sv
// Property checker for i2c_irq_vector, attached by bind below.
module i2c_irq_vector_chk
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  evt_pulse,
    input logic          bus_busy,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq,
    input logic [N-1:0]  flags,
    input logic [N-1:0]  mask,
    input logic [VW-1:0] vec_code
);
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((flags & $past(evt_pulse)) == $past(evt_pulse)));

    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !evt_pulse[0]) |=> !flags[0]);

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[1] && evt_pulse[1]) |=> flags[1]);

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    a_r4_enabled_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && mask[0]) |-> irq);

    a_r5_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && mask[0]) |-> (vec_code == VW'(1)));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) == '0) |-> (vec_code == '0));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_VEC && vec_code == VW'(1) && !evt_pulse[0]) |=> !flags[0]);

    a_r8_busy_view: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT) |-> (reg_rdata[BB_BIT] == bus_busy));
endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(.N(N), .DW(DW), .AW(AW), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .flags(flags), .mask(mask), .vec_code(vec_code)
);

// File: tb/i2c_irq_vector_bench.sv
module i2c_irq_vector_bench;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_pulse = '0;
    logic        rxd_read = 1'b0;
    logic        txd_write = 1'b0;
    logic        rsr_full = 1'b0;
    logic        bus_busy = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    i2c_irq_vector u_i2c_irq_vector (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rxd_read(rxd_read),
        .txd_write(txd_write), .rsr_full(rsr_full), .bus_busy(bus_busy),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {mask[6:0], events[6:0], expected vector[2:0], expected irq}
    localparam logic [17:0] TBL [9] = '{
        {7'h7F, 7'h01, 3'd1, 1'b1},
        {7'h7F, 7'h06, 3'd2, 1'b1},
        {7'h7F, 7'h60, 3'd6, 1'b1},
        {7'h7F, 7'h18, 3'd4, 1'b1},
        {7'h7E, 7'h03, 3'd2, 1'b1},
        {7'h00, 7'h7F, 3'd0, 1'b0},
        {7'h40, 7'h40, 3'd7, 1'b1},
        {7'h10, 7'h08, 3'd0, 1'b0},
        {7'h7F, 7'h00, 3'd0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [6:0] e);
        evt_pulse = e;
        tick();
        evt_pulse = '0;
    endtask

    task automatic rdvec(output logic [15:0] v);
        reg_addr = 2'd2; reg_rd = 1'b1;
        #1;
        v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();

        // R9: reset state
        check("R9 irq", {15'd0, irq}, 16'd0);
        peek(2'd0, v); check("R9 mask", v, 16'h0000);
        peek(2'd1, v); check("R9 status", v, 16'h0000);
        peek(2'd2, v); check("R9 vector", v, 16'h0000);

        // R1 R4 R5: table of mask/event patterns
        foreach (TBL[k]) begin
            wr(2'd1, 16'h007F);
            wr(2'd0, {9'd0, TBL[k][17:11]});
            pulse(TBL[k][10:4]);
            peek(2'd1, v); check("R1 status flags", v, {9'd0, TBL[k][10:4]});
            peek(2'd2, v); check("R5 vector", v, {13'd0, TBL[k][3:1]});
            check("R4 irq", {15'd0, irq}, {15'd0, TBL[k][0]});
        end

        // R4: mask readback, upper bits read as zero
        wr(2'd0, 16'hFFFF); peek(2'd0, v); check("R4 mask wide", v, 16'h007F);
        wr(2'd0, 16'h0055); peek(2'd0, v); check("R4 mask readback", v, 16'h0055);

        // R2: write-one-to-clear
        wr(2'd1, 16'h007F);
        pulse(7'h05);
        wr(2'd1, 16'h0001); peek(2'd1, v); check("R2 clear one", v, 16'h0004);
        wr(2'd1, 16'h0000); peek(2'd1, v); check("R2 zero write", v, 16'h0004);

        // R3: set and clear of the same flag in one cycle
        wr(2'd1, 16'h007F);
        pulse(7'h02);
        evt_pulse = 7'h02;
        wr(2'd1, 16'h0002);
        evt_pulse = '0;
        peek(2'd1, v); check("R3 set wins", v, 16'h0002);

        // R6: vector reads clear in priority order
        wr(2'd1, 16'h007F);
        wr(2'd0, 16'h007F);
        pulse(7'h23);
        rdvec(v); check("R6 first code", v, 16'd1);
        rdvec(v); check("R6 second code", v, 16'd2);
        rdvec(v); check("R6 third code", v, 16'd6);
        peek(2'd2, v); check("R6 drained", v, 16'd0);
        check("R6 irq low", {15'd0, irq}, 16'd0);

        // R6 R7: data-ready flags survive vector reads, clear on strobes
        pulse(7'h18);
        rdvec(v); check("R6 rx code", v, 16'd4);
        rdvec(v); check("R6 rx kept", v, 16'd4);
        rxd_read = 1'b1; tick(); rxd_read = 1'b0;
        peek(2'd2, v); check("R7 rx cleared", v, 16'd5);
        rdvec(v); check("R6 tx kept", v, 16'd5);
        peek(2'd2, v); check("R6 tx still", v, 16'd5);
        txd_write = 1'b1; tick(); txd_write = 1'b0;
        peek(2'd1, v); check("R7 tx cleared", v, 16'h0000);

        // R8: read-only levels
        bus_busy = 1'b1; rsr_full = 1'b1;
        peek(2'd1, v); check("R8 levels", v, 16'h1800);
        wr(2'd1, 16'h1800); peek(2'd1, v); check("R8 write ignored", v, 16'h1800);
        bus_busy = 1'b0;
        peek(2'd1, v); check("R8 busy follows", v, 16'h0800);
        rsr_full = 1'b0;
        peek(2'd1, v); check("R8 full follows", v, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule